// File: doc/BRIEF.md
# Beam Crossing Tick and Turn Counter

This block numbers accelerator crossings with a pair of counts. The tick counts crossings inside one revolution, with 159 crossings of 132 ns each. The turn counts revolutions. Both counts advance on a tick clock that runs at the crossing rate. A turn marker pulse, given on the first crossing of each revolution, sends the tick back to 1 and advances the turn.

The marker can be taken directly or through a fixed 26-stage delay line, chosen by a select bit. In delayed mode the same counter produces numbers for a second time zone that trails the first by 26 crossings.

Counting starts only at the first marker after a clear, and a flag reports when the pair is meaningful. Three clear sources are available:
- a force bit, which holds the clear for as long as it is set;
- a timing reset pulse, gated by its own enable;
- an initialize pulse, gated by its own enable.

The full turn count is brought out for monitoring. Its low bits are brought out separately for a downstream hub.

Top module: `xing_count_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `tick_o`, `turn_o` and `hub_turn_o` are 0 and `valid_o` is 0.
- R2: After any clear and before the first qualifying marker, tick clocks change nothing: `tick_o` stays 0, `turn_o` stays 0 and `valid_o` stays 0.
- R3: A qualifying marker sampled at a clock edge makes `tick_o` equal 1 from that edge on. If the counter was not counting, it also makes `turn_o` equal 1 and sets `valid_o` to 1. Otherwise it makes `turn_o` the previous turn plus 1.
- R4: At each edge with no marker, a counting tick increases by 1. It stops at its all-ones value (255 for 8 bits) instead of overflowing.
- R5: When a marker arrives while `turn_o` is all ones, `turn_o` wraps to 0 and `valid_o` stays 1.
- R6: `turn_o` carries the whole turn count. `hub_turn_o` always equals the low HUB_W bits of `turn_o`.
- R7: With `cfg_delay_sel_i`=1, a marker on `turn_mark_i` acts 26 edges after it was sampled. With 159-tick revolutions, the delayed tick reads 133 in the cycle just before the next raw marker acts.
- R8: A `tmg_rst_i` pulse clears the counter (R1 values) only when `cfg_tmg_rst_en_i` is 1. With the enable at 0, counting goes on unchanged.
- R9: While `cfg_force_rst_i` is 1, the counter stays cleared and markers are ignored. Counting resumes at the first marker after the bit returns to 0.
- R10: An `init_i` pulse clears the counter only when `cfg_init_rst_en_i` is 1. With the enable at 0, it has no effect.
- R11: Any clear also empties the delay line, so a marker taken in before the clear never arms the counter afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one edge per crossing |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| turn_mark_i | input | 1 | Turn marker pulse on the first crossing of a revolution |
| init_i | input | 1 | Initialize pulse |
| tmg_rst_i | input | 1 | Timing reset pulse |
| cfg_delay_sel_i | input | 1 | 1: use the delayed marker, 0: use the raw marker |
| cfg_tmg_rst_en_i | input | 1 | Lets the timing reset clear the counter |
| cfg_force_rst_i | input | 1 | Holds the counter cleared while 1 |
| cfg_init_rst_en_i | input | 1 | Lets the initialize pulse clear the counter |
| tick_o | output | TICK_W | Crossing number within the revolution |
| turn_o | output | TURN_W | Full revolution count for monitoring |
| hub_turn_o | output | HUB_W | Low revolution bits for the hub |
| valid_o | output | 1 | The pair is meaningful (a marker has been seen since the last clear) |

## Verification
The raw marker is driven with 159-tick spacing, to show the 1..159 tick walk and the turn increment. The same spacing in delayed mode separates a correct 26-edge shift, and the tick of 133 at the end of the first revolution, from an off-by-one in the delay line. A long run without markers tells saturation apart from wraparound of the tick. A marker on every edge drives the turn through its full range to show the wrap to 0. Each clear source is pulsed once with its enable off and once with it on, which separates the gating from the clearing itself. A marker placed just before a clear shows whether stale delay-line contents are discarded.

// File: rtl/xing_count_pkg.sv
package xing_count_pkg;

   // clear sources, each qualified by its own enable
   typedef struct packed {
      logic hold;    // level-sensitive force
      logic tmg;     // timing reset pulse
      logic init;    // initialize pulse
   } clr_src_t;

   localparam int unsigned CLR_SRC_N = $bits(clr_src_t);

   function automatic logic any_clear(clr_src_t req, clr_src_t en);
      clr_src_t q;
      q = req & en;
      return |q;
   endfunction

endpackage

// File: rtl/xing_clr_merge.sv
module xing_clr_merge
   import xing_count_pkg::*;
(
   input  clr_src_t req_i,
   input  clr_src_t en_i,
   output logic     clr_o
);
   assign clr_o = any_clear(req_i, en_i);
endmodule

// File: rtl/xing_mark_delay.sv
module xing_mark_delay #(
   parameter int unsigned STAGES = 26
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_i,
   input  logic mark_i,
   input  logic sel_i,
   output logic mark_o
);
   logic delayed;

   generate
      if (STAGES == 0) begin : g_bypass
         assign delayed = mark_i;
      end else if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= 1'b0;
            else if (flush_i) q <= 1'b0;
            else              q <= mark_i;
         end
         assign delayed = q;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sr <= '0;
            else if (flush_i) sr <= '0;
            else              sr <= {sr[STAGES-2:0], mark_i};
         end
         assign delayed = sr[STAGES-1];
      end
   endgenerate

   assign mark_o = sel_i ? delayed : mark_i;
endmodule

// File: rtl/xing_tt_counter.sv
module xing_tt_counter #(
   parameter int unsigned TICK_W = 8,
   parameter int unsigned TURN_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              mark_i,
   output logic [TICK_W-1:0] tick_o,
   output logic [TURN_W-1:0] turn_o,
   output logic              armed_o
);
   localparam logic [TICK_W-1:0] TICK_ONE = TICK_W'(1);
   localparam logic [TICK_W-1:0] TICK_TOP = '1;
   localparam logic [TURN_W-1:0] TURN_ONE = TURN_W'(1);

   logic [TICK_W-1:0] tick_q;
   logic [TURN_W-1:0] turn_q;
   logic              armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q  <= '0;
         turn_q  <= '0;
         armed_q <= 1'b0;
      end else if (clr_i) begin
         tick_q  <= '0;
         turn_q  <= '0;
         armed_q <= 1'b0;
      end else if (mark_i) begin
         tick_q  <= TICK_ONE;
         turn_q  <= armed_q ? turn_q + TURN_ONE : TURN_ONE;
         armed_q <= 1'b1;
      end else if (armed_q && (tick_q != TICK_TOP)) begin
         tick_q  <= tick_q + TICK_ONE;
      end
   end

   assign tick_o  = tick_q;
   assign turn_o  = turn_q;
   assign armed_o = armed_q;
endmodule

// File: rtl/xing_count_top.sv
module xing_count_top
   import xing_count_pkg::*;
#(
   parameter int unsigned TICK_W       = 8,
   parameter int unsigned TURN_W       = 32,
   parameter int unsigned HUB_W        = 16,
   parameter int unsigned DELAY_STAGES = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              turn_mark_i,
   input  logic              init_i,
   input  logic              tmg_rst_i,
   input  logic              cfg_delay_sel_i,
   input  logic              cfg_tmg_rst_en_i,
   input  logic              cfg_force_rst_i,
   input  logic              cfg_init_rst_en_i,
   output logic [TICK_W-1:0] tick_o,
   output logic [TURN_W-1:0] turn_o,
   output logic [HUB_W-1:0]  hub_turn_o,
   output logic              valid_o
);
   generate
      if (HUB_W > TURN_W) begin : g_bad_hub
         $error("HUB_W must not exceed TURN_W");
      end
      if (TICK_W < 2) begin : g_bad_tick
         $error("TICK_W must be at least 2");
      end
   endgenerate

   clr_src_t clr_req, clr_en;
   logic     clr_any;
   logic     mark_sel;

   assign clr_req = '{hold: cfg_force_rst_i, tmg: tmg_rst_i, init: init_i};
   assign clr_en  = '{hold: 1'b1, tmg: cfg_tmg_rst_en_i, init: cfg_init_rst_en_i};

   xing_clr_merge u_clr (
      .req_i (clr_req),
      .en_i  (clr_en),
      .clr_o (clr_any)
   );

   xing_mark_delay #(.STAGES(DELAY_STAGES)) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (clr_any),
      .mark_i  (turn_mark_i),
      .sel_i   (cfg_delay_sel_i),
      .mark_o  (mark_sel)
   );

   xing_tt_counter #(.TICK_W(TICK_W), .TURN_W(TURN_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_any),
      .mark_i  (mark_sel),
      .tick_o  (tick_o),
      .turn_o  (turn_o),
      .armed_o (valid_o)
   );

   assign hub_turn_o = turn_o[HUB_W-1:0];
endmodule

// File: rtl/xing_count_chk.sv
module xing_count_chk #(
   parameter int unsigned TICK_W = 8,
   parameter int unsigned TURN_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_any,
   input logic              mark_sel,
   input logic              cfg_force_rst_i,
   input logic [TICK_W-1:0] tick_o,
   input logic [TURN_W-1:0] turn_o,
   input logic              valid_o
);
   localparam logic [TICK_W-1:0] TOP = '1;

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_any |=> (!valid_o && tick_o == '0 && turn_o == '0)); // R8
   AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_force_rst_i |=> !valid_o); // R9
   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !mark_sel) |=> (!valid_o && tick_o == '0)); // R2
   AST_MARK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_sel && !clr_any) |=> (valid_o && tick_o == TICK_W'(1))); // R3
   AST_TURN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_sel && !clr_any && valid_o) |=> (turn_o == $past(turn_o) + TURN_W'(1))); // R5
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !mark_sel && !clr_any && tick_o != TOP) |=> (tick_o == $past(tick_o) + TICK_W'(1))); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !mark_sel && !clr_any && tick_o == TOP) |=> (tick_o == TOP)); // R4
endmodule

bind xing_count_top xing_count_chk #(.TICK_W(TICK_W), .TURN_W(TURN_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .clr_any         (clr_any),
   .mark_sel        (mark_sel),
   .cfg_force_rst_i (cfg_force_rst_i),
   .tick_o          (tick_o),
   .turn_o          (turn_o),
   .valid_o         (valid_o)
);

// File: tb/xing_count_tb.sv
module xing_count_top_tb_top;
   localparam int TW = 8, UW = 12, HW = 8, DS = 26, PER = 159;

   logic clk = 1'b0, rst_n = 1'b0;
   logic mark = 0, init = 0, tmg = 0, sel = 0, tmg_en = 0, force_r = 0, init_en = 0;
   logic [TW-1:0] tick;
   logic [UW-1:0] turn;
   logic [HW-1:0] hub;
   logic          valid;
   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   xing_count_top #(.TICK_W(TW), .TURN_W(UW), .HUB_W(HW), .DELAY_STAGES(DS)) dut_i (
      .clk(clk), .rst_n(rst_n), .turn_mark_i(mark), .init_i(init), .tmg_rst_i(tmg),
      .cfg_delay_sel_i(sel), .cfg_tmg_rst_en_i(tmg_en), .cfg_force_rst_i(force_r),
      .cfg_init_rst_en_i(init_en), .tick_o(tick), .turn_o(turn), .hub_turn_o(hub),
      .valid_o(valid));

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic state(string req, int t, int u, int v);
      chk({req, " tick"}, int'(tick), t);
      chk({req, " turn"}, int'(turn), u);
      chk({req, " valid"}, int'(valid), v);
      chk({req, " hub(R6)"}, int'(hub), u % (1 << HW));
   endtask

   // one tick clock edge; inputs set before, outputs read at the next falling edge
   task automatic step(logic m);
      mark = m;
      @(negedge clk);
      mark = 0;
   endtask

   task automatic steps(int n);
      for (int i = 0; i < n; i++) step(0);
   endtask

   task automatic hard_reset();
      {mark, init, tmg, sel, tmg_en, force_r, init_en} = '0;
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic t_reset();
      hard_reset();
      state("R1", 0, 0, 0);
   endtask

   task automatic t_idle();
      hard_reset();
      steps(20);
      state("R2 idle ticks", 0, 0, 0);
   endtask

   task automatic t_direct();
      hard_reset();
      init_en = 1; init = 1; step(0); init = 0;
      state("R10 init enabled", 0, 0, 0);
      step(1);
      state("R3 first marker", 1, 1, 1);
      steps(PER - 1);
      state("R4 last tick", PER, 1, 1);
      step(1);
      state("R3 second marker", 1, 2, 1);
   endtask

   task automatic t_sat();
      hard_reset();
      step(1);
      steps(300);
      state("R4 saturate", 255, 1, 1);
   endtask

   task automatic t_delay();
      hard_reset();
      sel = 1;
      step(1);
      steps(DS - 1);
      state("R7 before delayed marker", 0, 0, 0);
      step(0);
      state("R7 delayed marker acts", 1, 1, 1);
      steps(PER - 1 - DS);
      state("R7 end of first turn", 133, 1, 1);
      step(1);
      steps(DS - 1);
      chk("R7 tick before second", int'(tick), PER);
      step(0);
      state("R7 second delayed marker", 1, 2, 1);
   endtask

   task automatic t_tmg();
      hard_reset();
      step(1); steps(4);
      tmg = 1; step(0); tmg = 0;
      state("R8 disabled timing reset", 6, 1, 1);
      tmg_en = 1; tmg = 1; step(0); tmg = 0;
      state("R8 enabled timing reset", 0, 0, 0);
   endtask

   task automatic t_force();
      hard_reset();
      step(1); step(1);
      force_r = 1;
      step(0); step(1); steps(3); step(1);
      state("R9 held", 0, 0, 0);
      force_r = 0;
      steps(3);
      state("R9 released no marker", 0, 0, 0);
      step(1);
      state("R9 resume", 1, 1, 1);
   endtask

   task automatic t_init_gate();
      hard_reset();
      step(1); steps(2);
      init = 1; step(0); init = 0;
      state("R10 disabled init", 4, 1, 1);
   endtask

   task automatic t_flush();
      hard_reset();
      sel = 1; tmg_en = 1;
      step(1); steps(5);
      tmg = 1; step(0); tmg = 0;
      steps(DS + 5);
      state("R11 flushed marker", 0, 0, 0);
   endtask

   task automatic t_wrap();
      hard_reset();
      for (int i = 0; i < (1 << UW) - 1; i++) step(1);
      state("R5 top turn", 1, (1 << UW) - 1, 1);
      step(1);
      state("R5 wrap", 1, 0, 1);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_direct();
      t_sat();
      t_delay();
      t_tmg();
      t_force();
      t_init_gate();
      t_flush();
      t_wrap();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule